// File: doc/BRIEF.md
# Floating-Point Sample Formatter and Lane Splitter

This block is the first stage of a digital receive channel. A fast converter delivers one word per clock: a signed 16-bit mantissa, a 3-bit exponent, and a select bit that marks the sample as belonging to the first or second lane. The block scales each mantissa by its exponent to produce a 23-bit signed fixed-point value.

A 2-bit mode input decides how the scaled values are grouped. In single real mode every sample leaves on the real output. In complex mode samples are paired as I (select high) followed by Q (select low). In diversity mode samples are paired as channel A (select high) followed by channel B (select low).

Output data sits in registers and changes one clock after the sample that completes it. Each output group has its own one-cycle strobe. If the select sequence is broken, the block drops the partial pair and raises a sticky flag.

Top module: `fpin_front`

## Requirements
- R1: The fixed-point value is the two's-complement mantissa multiplied by 2 to the power of the exponent, held in 23 signed bits. Exponent 7 puts the mantissa in bits 22:7, and exponent 0 puts it, sign-extended, in bits 15:0.
- R2: Mode encoding: 2'b00 is single real, 2'b01 is complex, 2'b10 is diversity, and 2'b11 behaves exactly like 2'b00.
- R3: In single real mode every sample with `smp_valid` high appears on `real_data`, with `real_valid` pulsed for one cycle, on the clock after it is presented.
- R4: In any cycle at most one output group strobes, and only the group that belongs to the current mode.
- R5: In complex mode, a select-high sample is held as I. The next select-low sample completes the pair: `cplx_i` and `cplx_q` are loaded and a single `cplx_valid` pulse is given on the following clock.
- R6: In diversity mode, a select-high sample is held as channel A. The next select-low sample completes the pair: `div_a_valid` and `div_b_valid` pulse together, with the A and B values on their data ports.
- R7: In the paired modes, two cases are misalignment: a select-low sample with no held select-high sample, and a select-high sample arriving while one is already held. In both cases the incomplete pair gives no output and `misalign` goes high. It then stays high until reset. A repeated select-high sample replaces the held one.
- R8: A change of mode drops any held select-high sample, so a select-low sample that follows it counts as misaligned.
- R9: Synchronous active-high reset clears all strobes, all data outputs, the held sample and `misalign`.
- R10: Cycles with `smp_valid` low produce no strobe and do not disturb a held sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Grouping mode |
| smp_valid | input | 1 | Sample present this cycle |
| smp_mant | input | 16 | Signed mantissa |
| smp_exp | input | 3 | Exponent (scale by 2^exp) |
| smp_ab | input | 1 | Lane select: high = I/A, low = Q/B |
| real_valid | output | 1 | Single real strobe |
| real_data | output | 23 | Single real value |
| cplx_valid | output | 1 | Complex pair strobe |
| cplx_i | output | 23 | In-phase value |
| cplx_q | output | 23 | Quadrature value |
| div_a_valid | output | 1 | Diversity channel A strobe |
| div_a_data | output | 23 | Diversity channel A value |
| div_b_valid | output | 1 | Diversity channel B strobe |
| div_b_data | output | 23 | Diversity channel B value |
| misalign | output | 1 | Sticky pairing error flag |

## Verification
The assertions assume that `smp_valid`, `smp_ab` and `mode_sel` are driven to known values at every clock edge after reset, and that a pair always closes on a select-low sample. The stimulus drives every input from the falling edge and holds it stable across the rising edge. It keeps `smp_valid` low whenever it is not presenting a sample. Mode changes happen only together with a presented sample, so the bench's reference model sees every change of grouping at the same edge the block does.

// File: rtl/fpin_pkg.sv
package fpin_pkg;

    localparam int MANT_W  = 16;
    localparam int EXP_W   = 3;
    localparam int MAX_SH  = (1 << EXP_W) - 1;
    localparam int FIX_W   = MANT_W + MAX_SH;

    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_CPLX = 2'b01,
        MODE_DIV  = 2'b10,
        MODE_RSVD = 2'b11
    } in_mode_e;

    typedef logic signed [FIX_W-1:0] fix_t;

    typedef struct packed {
        logic ab;
        fix_t val;
    } samp_t;

    function automatic in_mode_e eff_mode(input logic [1:0] m);
        in_mode_e r;
        r = in_mode_e'(m);
        if (r == MODE_RSVD) r = MODE_REAL;
        return r;
    endfunction

    function automatic fix_t to_fixed(input logic [MANT_W-1:0] m,
                                      input logic [EXP_W-1:0] e);
        fix_t s;
        s = {{(FIX_W-MANT_W){m[MANT_W-1]}}, m};
        return s <<< e;
    endfunction

endpackage

// File: rtl/fp_shift.sv
module fp_shift
    import fpin_pkg::*;
(
    input  logic              vld_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic              ab_i,
    output logic              vld_o,
    output samp_t             samp_o
);

    always_comb begin
        vld_o      = vld_i;
        samp_o.ab  = ab_i;
        samp_o.val = to_fixed(mant_i, exp_i);
    end

endmodule

// File: rtl/pair_steer.sv
module pair_steer
    import fpin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_i,
    input  logic        vld_i,
    input  samp_t       samp_i,
    output logic        real_v_o,
    output fix_t        real_d_o,
    output logic        cplx_v_o,
    output fix_t        cplx_i_o,
    output fix_t        cplx_q_o,
    output logic        div_a_v_o,
    output fix_t        div_a_o,
    output logic        div_b_v_o,
    output fix_t        div_b_o,
    output logic        mis_o
);

    in_mode_e cur_mode;
    in_mode_e mode_q;
    logic     mode_chg;
    logic     pend;
    logic     pend_eff;
    fix_t     pend_val;

    always_comb begin
        cur_mode = eff_mode(mode_i);
        mode_chg = (cur_mode != mode_q);
        pend_eff = pend && !mode_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_REAL;
            pend      <= 1'b0;
            pend_val  <= '0;
            real_v_o  <= 1'b0;
            real_d_o  <= '0;
            cplx_v_o  <= 1'b0;
            cplx_i_o  <= '0;
            cplx_q_o  <= '0;
            div_a_v_o <= 1'b0;
            div_b_v_o <= 1'b0;
            div_a_o   <= '0;
            div_b_o   <= '0;
            mis_o     <= 1'b0;
        end else begin
            mode_q    <= cur_mode;
            real_v_o  <= 1'b0;
            cplx_v_o  <= 1'b0;
            div_a_v_o <= 1'b0;
            div_b_v_o <= 1'b0;
            if (mode_chg) pend <= 1'b0;
            if (vld_i) begin
                case (cur_mode)
                    MODE_CPLX, MODE_DIV: begin
                        if (samp_i.ab) begin
                            if (pend_eff) mis_o <= 1'b1;
                            pend     <= 1'b1;
                            pend_val <= samp_i.val;
                        end else if (pend_eff) begin
                            pend <= 1'b0;
                            if (cur_mode == MODE_CPLX) begin
                                cplx_v_o <= 1'b1;
                                cplx_i_o <= pend_val;
                                cplx_q_o <= samp_i.val;
                            end else begin
                                div_a_v_o <= 1'b1;
                                div_b_v_o <= 1'b1;
                                div_a_o   <= pend_val;
                                div_b_o   <= samp_i.val;
                            end
                        end else begin
                            mis_o <= 1'b1;
                        end
                    end
                    default: begin
                        real_v_o <= 1'b1;
                        real_d_o <= samp_i.val;
                    end
                endcase
            end
        end
    end

    // R4: groups never strobe together
    a_r4_one_group: assert property (@(posedge clk) disable iff (rst)
        $onehot0({real_v_o, cplx_v_o, div_a_v_o}));

    // R3 / R10: a real strobe needs a presented sample one cycle earlier
    a_r3_real_from_sample: assert property (@(posedge clk) disable iff (rst)
        real_v_o |-> $past(vld_i));

    // R5: a complex pair closes on a select-low sample
    a_r5_cplx_closes_low: assert property (@(posedge clk) disable iff (rst)
        cplx_v_o |-> $past(vld_i && !samp_i.ab));

    // R6: diversity strobes pulse together and close on select-low
    a_r6_div_pair: assert property (@(posedge clk) disable iff (rst)
        div_a_v_o |-> (div_b_v_o && $past(vld_i && !samp_i.ab)));

    // R7: misalignment flag is sticky
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        mis_o |=> mis_o);

endmodule

// File: rtl/fpin_front.sv
module fpin_front
    import fpin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              smp_valid,
    input  logic [MANT_W-1:0] smp_mant,
    input  logic [EXP_W-1:0]  smp_exp,
    input  logic              smp_ab,
    output logic              real_valid,
    output logic [FIX_W-1:0]  real_data,
    output logic              cplx_valid,
    output logic [FIX_W-1:0]  cplx_i,
    output logic [FIX_W-1:0]  cplx_q,
    output logic              div_a_valid,
    output logic [FIX_W-1:0]  div_a_data,
    output logic              div_b_valid,
    output logic [FIX_W-1:0]  div_b_data,
    output logic              misalign
);

    logic  cv_vld;
    samp_t cv_samp;
    fix_t  r_d, c_i, c_q, d_a, d_b;

    fp_shift u_shift (
        .vld_i  (smp_valid),
        .mant_i (smp_mant),
        .exp_i  (smp_exp),
        .ab_i   (smp_ab),
        .vld_o  (cv_vld),
        .samp_o (cv_samp)
    );

    pair_steer u_steer (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_sel),
        .vld_i     (cv_vld),
        .samp_i    (cv_samp),
        .real_v_o  (real_valid),
        .real_d_o  (r_d),
        .cplx_v_o  (cplx_valid),
        .cplx_i_o  (c_i),
        .cplx_q_o  (c_q),
        .div_a_v_o (div_a_valid),
        .div_a_o   (d_a),
        .div_b_v_o (div_b_valid),
        .div_b_o   (d_b),
        .mis_o     (misalign)
    );

    assign real_data  = r_d;
    assign cplx_i     = c_i;
    assign cplx_q     = c_q;
    assign div_a_data = d_a;
    assign div_b_data = d_b;

endmodule

// File: tb/fpin_front_test.sv
module fpin_front_test;

    logic        clk = 0;
    logic        rst = 1;
    logic [1:0]  mode_sel = 0;
    logic        smp_valid = 0;
    logic [15:0] smp_mant = 0;
    logic [2:0]  smp_exp = 0;
    logic        smp_ab = 0;
    logic        real_valid, cplx_valid, div_a_valid, div_b_valid, misalign;
    logic [22:0] real_data, cplx_i, cplx_q, div_a_data, div_b_data;

    always #2 clk = ~clk;

    fpin_front uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .smp_valid(smp_valid),
        .smp_mant(smp_mant), .smp_exp(smp_exp), .smp_ab(smp_ab),
        .real_valid(real_valid), .real_data(real_data),
        .cplx_valid(cplx_valid), .cplx_i(cplx_i), .cplx_q(cplx_q),
        .div_a_valid(div_a_valid), .div_a_data(div_a_data),
        .div_b_valid(div_b_valid), .div_b_data(div_b_data),
        .misalign(misalign)
    );

    typedef struct {
        int          kind;   // 0 real, 1 complex, 2 diversity
        logic [22:0] d0;
        logic [22:0] d1;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    int          m_prev = 0;
    bit          m_have = 0;
    logic [22:0] m_hold = 0;
    bit          m_mis = 0;

    task automatic chk(input bit ok, input string req, input logic [45:0] act, input logic [45:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [22:0] scaled(input logic [15:0] m, input logic [2:0] e);
        int v;
        v = $signed(m) * (2 ** e);
        return v[22:0];
    endfunction

    task automatic send(input logic [1:0] md, input logic [15:0] m, input logic [2:0] e, input bit ab);
        int em;
        logic [22:0] v;
        exp_t it;
        @(negedge clk);
        mode_sel = md; smp_mant = m; smp_exp = e; smp_ab = ab; smp_valid = 1;
        em = (md == 2'b11) ? 0 : int'(md);
        v = scaled(m, e);
        if (em != m_prev) begin m_have = 0; m_prev = em; end
        if (em == 0) begin
            it.kind = 0; it.d0 = v; it.d1 = 0; sb.push_back(it);
        end else if (ab) begin
            if (m_have) m_mis = 1;
            m_have = 1; m_hold = v;
        end else if (m_have) begin
            it.kind = em; it.d0 = m_hold; it.d1 = v; sb.push_back(it);
            m_have = 0;
        end else m_mis = 1;
    endtask

    task automatic quiet(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_valid = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; smp_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_prev = 0; m_have = 0; m_mis = 0;
        chk(!real_valid && !cplx_valid && !div_a_valid && !div_b_valid && !misalign,
            "R9 strobes", {real_valid, cplx_valid, div_a_valid, div_b_valid, misalign}, 0);
        chk(real_data == 0 && cplx_i == 0 && cplx_q == 0 && div_a_data == 0 && div_b_data == 0,
            "R9 data", real_data | cplx_i | cplx_q | div_a_data | div_b_data, 0);
    endtask

    task automatic chk_mis(input string req);
        chk(misalign == m_mis, req, misalign, m_mis);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (div_a_valid != div_b_valid)
                chk(0, "R6 strobes together", div_a_valid, div_b_valid);
            if (real_valid || cplx_valid || div_a_valid) begin
                exp_t it;
                int k;
                k = real_valid ? 0 : (cplx_valid ? 1 : 2);
                if (sb.size() == 0) begin
                    chk(0, "R4 unexpected strobe", k, 99);
                end else begin
                    it = sb.pop_front();
                    chk(it.kind == k, "R4 strobe group", k, it.kind);
                    if (k == 0)
                        chk(real_data == it.d0, "R1 R3 real value", real_data, it.d0);
                    else if (k == 1)
                        chk({cplx_i, cplx_q} == {it.d0, it.d1}, "R5 complex pair",
                            {cplx_i, cplx_q}, {it.d0, it.d1});
                    else
                        chk({div_a_data, div_b_data} == {it.d0, it.d1}, "R6 diversity pair",
                            {div_a_data, div_b_data}, {it.d0, it.d1});
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 R3: single real, all exponents, extremes
        for (int e = 0; e < 8; e++) send(2'b00, 16'h8000, 3'(e), 0);
        for (int e = 0; e < 8; e++) send(2'b00, 16'h7fff, 3'(e), 1);
        send(2'b00, 16'h1234, 3'd3, 0);
        send(2'b00, 16'hffff, 3'd7, 1);
        // R2: reserved code acts as real
        send(2'b11, 16'h0a5a, 3'd5, 1);
        send(2'b11, 16'hc001, 3'd1, 0);
        quiet(3);
        chk(sb.size() == 0, "R3 R2 all real delivered", sb.size(), 0);
        chk_mis("R7 no flag in real mode");
        // R5: complex pairs, back to back and with gaps (R10)
        send(2'b01, 16'h0100, 3'd7, 1);
        send(2'b01, 16'hff00, 3'd7, 0);
        send(2'b01, 16'h4321, 3'd2, 1);
        quiet(4);
        chk(!cplx_valid, "R10 idle holds pair", cplx_valid, 0);
        send(2'b01, 16'h8765, 3'd4, 0);
        quiet(3);
        chk(sb.size() == 0, "R5 complex delivered", sb.size(), 0);
        chk_mis("R5 no flag on clean pairs");
        // R6: diversity pairs
        send(2'b10, 16'h7777, 3'd0, 1);
        send(2'b10, 16'h9999, 3'd6, 0);
        send(2'b10, 16'h0001, 3'd7, 1);
        quiet(2);
        send(2'b10, 16'hfffe, 3'd3, 0);
        quiet(3);
        chk(sb.size() == 0, "R6 diversity delivered", sb.size(), 0);
        chk_mis("R6 no flag on clean pairs");
        // R7: low without high in diversity
        send(2'b10, 16'h1111, 3'd1, 0);
        quiet(3);
        chk_mis("R7 lone low flags");
        chk(m_mis == 1, "R7 model flag", m_mis, 1);
        send(2'b10, 16'h2222, 3'd2, 1);
        send(2'b10, 16'h3333, 3'd2, 0);
        quiet(3);
        chk_mis("R7 flag sticky after good pair");
        // R7: repeated high in complex replaces held sample
        do_reset();
        send(2'b01, 16'h5555, 3'd7, 1);
        send(2'b01, 16'h6666, 3'd7, 1);
        send(2'b01, 16'h0777, 3'd7, 0);
        quiet(3);
        chk_mis("R7 double high flags");
        chk(sb.size() == 0, "R7 second high paired", sb.size(), 0);
        // R8: mode change drops held sample
        do_reset();
        send(2'b01, 16'h1357, 3'd4, 1);
        send(2'b10, 16'h2468, 3'd4, 0);
        quiet(3);
        chk_mis("R8 mode change drops held");
        chk(!cplx_valid && !div_a_valid, "R8 no pair output", {cplx_valid, div_a_valid}, 0);
        do_reset();
        chk(!misalign, "R9 flag cleared", misalign, 0);
        send(2'b00, 16'h4000, 3'd7, 0);
        quiet(3);
        chk(sb.size() == 0, "R3 after reset", sb.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule